// File: doc/BRIEF.md
# Alias-Method Discrete Sampler

This block turns uniformly distributed random bits into samples from an arbitrary discrete distribution by Walker's alias method. Each cycle it can take one wide random word. The high bits of the word form a uniform index X. The low bits form a uniform fixed-point fraction U. A table with one entry per outcome holds a threshold F(X) and an alternative outcome A(X). The sample is X when U does not exceed F(X), and A(X) when it does. No cumulative search is made.

The path has two register stages. In the first cycle the fields are captured and the table is read. In the second cycle the fraction is compared with the threshold, and the chosen index is registered as the output. The output uses a valid/ready handshake. While a sample waits at the output, the whole path stalls.

The output slot is a two-state machine. In SLOT_EMPTY it moves to SLOT_FULL when the path advances with a live first stage (transition *fill*). In SLOT_FULL it returns to SLOT_EMPTY when the consumer takes the sample and the first stage is empty (transition *drain*). It stays in SLOT_FULL when a take and a new sample land in the same cycle (transition *refill*). It also stays in SLOT_FULL while out_ready is low (transition *hold*). The table contents come from a parameter, which is computed by a package function by default.

Top module: `alias_sampler`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: The random word in_rnd is split as X = in_rnd[IDX_W+THR_W-1:THR_W] and U = in_rnd[THR_W-1:0]. Each table word holds A(X) in bits [IDX_W+THR_W-1:THR_W] and F(X) in bits [THR_W-1:0].
- R3: When U is less than or equal to F(X), the sample is X. This includes the case U equal to F(X).
- R4: When U is greater than F(X), the sample is A(X).
- R5: When F(X) is all ones, the sample is always X, whatever U is.
- R6: A word accepted at a clock edge appears on out_sample with out_valid two edges later, provided out_ready stays high. One word can be accepted per cycle.
- R7: While out_valid is 1 and out_ready is 0, out_sample and out_valid hold, and in_ready is 0.
- R8: Every accepted word yields exactly one sample. Samples leave in the order of acceptance, with none lost or duplicated across stalls.
- R9: The table has 2**IDX_W entries, one per outcome, and both index 0 and the top index are addressable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Random word present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_rnd | input | IDX_W+THR_W | Uniform random word (index above fraction) |
| out_valid | output | 1 | Sample present |
| out_ready | input | 1 | Consumer takes the sample this cycle |
| out_sample | output | IDX_W | Drawn outcome index |

## Verification
The output slot can drain a held sample and refill it with the next one in the same cycle. This happens when out_ready rises while a word already sits in the first stage and in_valid stays high. The bench provokes it with a long stream of valid words under a random out_ready pattern. A queue-based reference model then checks that each drawn value leaves exactly once and in acceptance order. In the free-running phase the model also checks that accept and emit overlap every cycle at a fixed distance of two edges.

// File: rtl/alias_pkg.sv
package alias_pkg;

    localparam int DEF_IDX_W = 7;
    localparam int DEF_THR_W = 31;
    localparam int DEF_DEPTH = 2 ** DEF_IDX_W;
    localparam int DEF_WORD_W = DEF_IDX_W + DEF_THR_W;

    typedef logic [DEF_DEPTH-1:0][DEF_WORD_W-1:0] def_table_t;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_e;

    function automatic def_table_t default_table();
        def_table_t t;
        for (int i = 0; i < DEF_DEPTH; i++) begin
            logic [DEF_THR_W-1:0] thr;
            logic [DEF_IDX_W-1:0] alt;
            logic [31:0] mix;
            mix = i * 32'h9E3779B1;
            thr = (i == 0) ? '1 : mix[DEF_THR_W-1:0];
            alt = DEF_IDX_W'((i * 37 + 11) % DEF_DEPTH);
            t[i] = {alt, thr};
        end
        return t;
    endfunction

endpackage

// File: rtl/alias_field_split.sv
module alias_field_split #(
    parameter int IDX_W = 7,
    parameter int THR_W = 31
) (
    input  logic [IDX_W+THR_W-1:0] rnd,
    output logic [IDX_W-1:0]       idx,
    output logic [THR_W-1:0]       frac
);
    localparam int RND_W = IDX_W + THR_W;

    assign idx  = rnd[RND_W-1:THR_W];
    assign frac = rnd[THR_W-1:0];
endmodule

// File: rtl/alias_rom.sv
module alias_rom #(
    parameter int IDX_W = 7,
    parameter int THR_W = 31,
    parameter logic [(2**IDX_W)-1:0][IDX_W+THR_W-1:0] TABLE = '0
) (
    input  logic                   clk,
    input  logic                   en,
    input  logic [IDX_W-1:0]       addr,
    output logic [IDX_W+THR_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (en) begin
            word <= TABLE[addr];
        end
    end
endmodule

// File: rtl/alias_select.sv
module alias_select #(
    parameter int IDX_W = 7,
    parameter int THR_W = 31
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   a_vld,
    input  logic [IDX_W-1:0]       a_x,
    input  logic [THR_W-1:0]       a_u,
    input  logic [IDX_W+THR_W-1:0] a_word,
    output logic                   out_valid,
    output logic [IDX_W-1:0]       out_sample
);
    import alias_pkg::*;

    localparam int WORD_W = IDX_W + THR_W;

    slot_e slot_q, slot_d;
    logic [THR_W-1:0] a_thr;
    logic [IDX_W-1:0] a_alt;
    logic             keep_x;

    assign a_thr  = a_word[THR_W-1:0];
    assign a_alt  = a_word[WORD_W-1:THR_W];
    assign keep_x = (a_u <= a_thr);

    always_comb begin
        slot_d = slot_q;
        unique case (slot_q)
            SLOT_EMPTY: if (en && a_vld)  slot_d = SLOT_FULL;
            SLOT_FULL:  if (en && !a_vld) slot_d = SLOT_EMPTY;
            default:    slot_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= SLOT_EMPTY;
        end else begin
            slot_q <= slot_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_sample <= '0;
        end else if (en && a_vld) begin
            out_sample <= keep_x ? a_x : a_alt;
        end
    end

    assign out_valid = (slot_q == SLOT_FULL);

    assert_all_ones_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && a_vld && (a_thr == '1)) |=> (out_sample == $past(a_x)));

    assert_above_takes_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && a_vld && (a_u > a_thr)) |=> (out_sample == $past(a_alt)));

    assert_at_or_below_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && a_vld && (a_u <= a_thr)) |=> (out_sample == $past(a_x)));
endmodule

// File: rtl/alias_sampler.sv
module alias_sampler #(
    parameter int IDX_W = alias_pkg::DEF_IDX_W,
    parameter int THR_W = alias_pkg::DEF_THR_W,
    parameter logic [(2**IDX_W)-1:0][IDX_W+THR_W-1:0] TABLE = alias_pkg::default_table()
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [IDX_W+THR_W-1:0] in_rnd,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [IDX_W-1:0]       out_sample
);
    localparam int WORD_W = IDX_W + THR_W;

    logic              adv;
    logic [IDX_W-1:0]  in_x;
    logic [THR_W-1:0]  in_u;
    logic              a_vld;
    logic [IDX_W-1:0]  a_x;
    logic [THR_W-1:0]  a_u;
    logic [WORD_W-1:0] a_word;

    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;

    alias_field_split #(.IDX_W(IDX_W), .THR_W(THR_W)) u_split (
        .rnd (in_rnd),
        .idx (in_x),
        .frac(in_u)
    );

    alias_rom #(.IDX_W(IDX_W), .THR_W(THR_W), .TABLE(TABLE)) u_rom (
        .clk (clk),
        .en  (adv),
        .addr(in_x),
        .word(a_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_vld <= 1'b0;
            a_x   <= '0;
            a_u   <= '0;
        end else if (adv) begin
            a_vld <= in_valid;
            a_x   <= in_x;
            a_u   <= in_u;
        end
    end

    alias_select #(.IDX_W(IDX_W), .THR_W(THR_W)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (adv),
        .a_vld     (a_vld),
        .a_x       (a_x),
        .a_u       (a_u),
        .a_word    (a_word),
        .out_valid (out_valid),
        .out_sample(out_sample)
    );

    assert_hold_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);

    assert_hold_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_sample));

    assert_accept_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> a_vld);

    assert_stage_feeds_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_vld && adv) |=> out_valid);
endmodule

// File: tb/alias_sampler_bench.sv
module alias_sampler_bench;
    localparam int IW = 7;
    localparam int TW = 31;
    localparam int DEPTH = 2 ** IW;
    localparam int RW = IW + TW;

    typedef logic [DEPTH-1:0][RW-1:0] tab_t;
    typedef struct {
        int    val;
        int    cyc;
        string tag;
    } item_t;

    function automatic logic [TW-1:0] thr_of(int i);
        case (i % 4)
            0: return '1;
            1: return '0;
            2: return 31'h4000_0000;
            default: return TW'(i) << 20;
        endcase
    endfunction

    function automatic int alt_of(int i);
        return DEPTH - 1 - i;
    endfunction

    function automatic tab_t build_tab();
        tab_t t;
        for (int i = 0; i < DEPTH; i++) t[i] = {IW'(alt_of(i)), thr_of(i)};
        return t;
    endfunction

    logic          clk = 0;
    logic          rst_n = 0;
    logic          in_valid = 0;
    logic          in_ready;
    logic [RW-1:0] in_rnd = '0;
    logic          out_valid;
    logic          out_ready = 0;
    logic [IW-1:0] out_sample;

    alias_sampler #(.IDX_W(IW), .THR_W(TW), .TABLE(build_tab())) u_alias_sampler (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_rnd(in_rnd), .out_valid(out_valid), .out_ready(out_ready),
        .out_sample(out_sample)
    );

    always #2 clk = ~clk;

    int    total = 0;
    int    bad = 0;
    int    ncyc = 0;
    bit    free_mode = 1;
    bit    prev_hold = 0;
    int    held_val = 0;
    bit    done = 0;
    item_t q[$];

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [RW-1:0] mk(int x, logic [TW-1:0] u);
        return {IW'(x), u};
    endfunction

    task automatic step(bit iv, logic [RW-1:0] r, bit ordy);
        @(negedge clk);
        in_valid = iv;
        in_rnd = r;
        out_ready = ordy;
        #1;
        if (prev_hold) begin
            check(out_valid == 1'b1, "R7 valid held", int'(out_valid), 1);
            check(int'(out_sample) == held_val, "R7 sample held", int'(out_sample), held_val);
        end
        if (out_valid && !ordy) check(in_ready == 1'b0, "R7 in_ready low", int'(in_ready), 0);
        if (in_valid && in_ready) begin
            item_t it;
            int x;
            logic [TW-1:0] u;
            x = int'(r[RW-1:TW]);
            u = r[TW-1:0];
            it.cyc = ncyc;
            if (thr_of(x) == '1) begin
                it.val = x; it.tag = "R5";
            end else if (u <= thr_of(x)) begin
                it.val = x; it.tag = "R3";
            end else begin
                it.val = alt_of(x); it.tag = "R4";
            end
            q.push_back(it);
        end
        if (out_valid && out_ready) begin
            if (q.size() == 0) begin
                check(1'b0, "R8 spurious sample", int'(out_sample), -1);
            end else begin
                item_t it;
                it = q.pop_front();
                check(int'(out_sample) == it.val, it.tag, int'(out_sample), it.val);
                if (free_mode) check(ncyc == it.cyc + 2, "R6 latency", ncyc - it.cyc, 2);
            end
        end
        prev_hold = out_valid && !ordy;
        held_val = int'(out_sample);
        ncyc++;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", ncyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        @(negedge clk);
        rst_n = 1;
        #1;
        check(out_valid == 1'b0, "R1 out_valid after release", int'(out_valid), 0);

        // R2/R3/R4/R5/R9 directed corners, consumer always ready
        step(1, mk(5, '0), 1);              // R3: F=0, U=0 equal -> X
        step(1, mk(5, 31'd1), 1);           // R4: U just above -> alias 122
        step(1, mk(8, '1), 1);              // R5: F all ones, U all ones -> X
        step(1, mk(2, 31'h4000_0000), 1);   // R3: U equal to F
        step(1, mk(2, 31'h4000_0001), 1);   // R4: U one above F
        step(1, mk(0, '1), 1);              // R9: first entry
        step(1, mk(127, '1), 1);            // R9: last entry -> alias 0
        step(1, mk(127, TW'(127) << 20), 1);// R9/R3: last entry at threshold
        step(1, mk(4, 31'd123), 1);         // R5 with mid U
        step(0, '0, 1);
        step(0, '0, 1);
        step(0, '0, 1);

        // R6: free running, random validity
        for (int k = 0; k < 400; k++)
            step(($urandom % 4) != 0, RW'({$urandom, $urandom}), 1);
        for (int k = 0; k < 3; k++) step(0, '0, 1);

        // R7/R8: random back-pressure with continuous input (drain and refill together)
        free_mode = 0;
        for (int k = 0; k < 3000; k++)
            step((k % 7) != 6, RW'({$urandom, $urandom}), ($urandom % 3) != 0);
        for (int k = 0; k < 10; k++) step(0, '0, 1);
        check(q.size() == 0, "R8 all drained", q.size(), 0);
        check(out_valid == 1'b0, "R8 idle after drain", int'(out_valid), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule